// File: doc/BRIEF.md
# Cascaded 24-Source Interrupt Aggregator

This block collects 24 level-sensitive interrupt lines into three banks of eight. Each bank is a priority stage with its own mask byte and in-service byte. The three bank requests feed fixed inputs of a fourth stage, the master, which also has a mask and in-service byte. The master drives one request line to the processor, together with a vector that identifies the winning line. When the processor takes the request with an acknowledge strobe, in-service bits are set in both the bank and the master. Software retires the interrupt with two specific end-of-interrupt writes, first to the bank and then to the master.

Software writes bytes through a port made of an address, data and a write strobe. It reads pending lines, in-service bits and masks through a combinational read port. The offer logic is a two-state machine. In `ST_IDLE` no request is shown. The transition *present* moves to `ST_OFFER` when an eligible line exists, and it latches that line's index. In `ST_OFFER` the request is high. The *retarget* transition stays in `ST_OFFER` and follows the current winner. The *take* transition returns to `ST_IDLE` on an acknowledge and commits the in-service bits. The *withdraw* transition returns to `ST_IDLE` when no eligible line remains.

Top module: `irq_cascade_agg`

## Requirements
- R1: After reset, every bank mask and the master mask read 0xFF, every in-service byte reads 0x00, and `irq_req` is low.
- R2: A write to a mask address (bank 0: 0x537, bank 1: 0x53B, bank 2: 0x53D, master: 0x535) loads the byte. A mask bit of 1 blocks its line and a 0 enables it. The master needs bits 1, 3 and 4 clear (for example 0x44) before any bank request passes.
- R3: The lines are level-sensitive. One clock edge after an unmasked and unblocked line is high, `irq_req` is high. If every eligible line falls before an acknowledge, the request is withdrawn at the next edge.
- R4: `irq_vector` equals 0x800 + (global line index × 16). Bank b, line n has global index 8·b + n.
- R5: Within a stage, the lowest-numbered eligible line wins. Bank 0 drives master input 1, bank 1 drives input 3 and bank 2 drives input 4, so bank 0 beats bank 1 and bank 1 beats bank 2.
- R6: An `irq_ack` pulse while `irq_req` is high sets the in-service bit of the offered line in its bank. It also sets master in-service bit 1, 3 or 4 for that bank.
- R7: An in-service bit blocks its own line and every higher-numbered line of the same stage. A set master bit therefore blocks its bank and every bank on a higher master input.
- R8: A byte 0xE0|n written to a command address (bank 0: 0x536, bank 1: 0x53A, bank 2: 0x53C, master: 0x534) clears only in-service bit n of that stage.
- R9: A command byte whose bits 7:5 are not 111, or any write to an address outside 0x534–0x53D, leaves every mask and in-service bit unchanged.
- R10: Reading a command address returns the stage's pending byte (request AND NOT mask) when `rd_isr_sel` is 0, and its in-service byte when it is 1. Reading a mask address returns the mask. Any other address reads 0.
- R11: A line that is still high after both end-of-interrupt writes, and is still unmasked, requests again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_lvl | input | 24 | Level interrupt lines, bit i is global line i |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Write byte address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 12 | Read byte address |
| rd_isr_sel | input | 1 | At a command address: 0 selects pending, 1 selects in-service |
| rd_data | output | 8 | Read data |
| irq_ack | input | 1 | Processor takes the offered request |
| irq_req | output | 1 | Request to the processor |
| irq_vector | output | 12 | Vector of the offered line |

## Verification
Some properties are checked by assertions on every cycle. Mask writes load the data byte. Malformed command bytes leave the in-service bits unchanged. An acknowledge sets the addressed in-service bit in both stages, and a valid end-of-interrupt clears its bit. A stage winner is never masked or blocked. The vector stays aligned and inside its range, and the request is withdrawn when no winner remains. Other behaviour depends on the order of events and only the bench scenarios can show it: which bank wins across the master, that the master in-service bit still blocks after the bank end-of-interrupt, that the line requests again after both end-of-interrupt writes, and that the read port agrees with the reference model across random mask, acknowledge and end-of-interrupt sequences.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int LINES     = 8;
    localparam int GROUPS    = 3;
    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 8;
    localparam int IDX_W     = $clog2(LINES);
    localparam int SRC_N     = LINES * GROUPS;
    localparam int SRC_IDX_W = $clog2(SRC_N);
    localparam int VEC_W     = 12;
    localparam int VEC_SHIFT = 4;
    localparam logic [VEC_W-1:0]  VEC_BASE   = 12'h800;
    localparam logic [ADDR_W-1:0] MASTER_CMD = 12'h534;
    localparam logic [2:0]        EOI_TAG    = 3'b111;

    typedef enum logic {
        ST_IDLE,
        ST_OFFER
    } offer_st_t;

    // Command address of a bank; its mask byte sits one above.
    function automatic logic [ADDR_W-1:0] bank_cmd_addr(input int g);
        case (g)
            0:       return 12'h536;
            1:       return 12'h53A;
            default: return 12'h53C;
        endcase
    endfunction

    // Master input that a bank is wired to.
    function automatic int bank_master_line(input int g);
        case (g)
            0:       return 1;
            1:       return 3;
            default: return 4;
        endcase
    endfunction
endpackage

// File: rtl/irqagg_pick.sv
module irqagg_pick #(
    parameter int N   = 8,
    parameter int N_W = $clog2(N)
) (
    input  logic [N-1:0]   pend,
    input  logic [N-1:0]   in_svc,
    output logic           win_vld,
    output logic [N_W-1:0] win_idx
);
    always_comb begin
        logic blocked;
        blocked = 1'b0;
        win_vld = 1'b0;
        win_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (!blocked && !win_vld) begin
                if (in_svc[i]) begin
                    blocked = 1'b1;
                end else if (pend[i]) begin
                    win_vld = 1'b1;
                    win_idx = N_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/irqagg_stage.sv
module irqagg_stage
    import irqagg_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CMD_ADDR = 12'h536
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LINES-1:0]  req_in,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_idx,
    output logic [LINES-1:0]  mask_q,
    output logic [LINES-1:0]  isr_q,
    output logic [LINES-1:0]  pend,
    output logic              win_vld,
    output logic [IDX_W-1:0]  win_idx
);
    localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(CMD_ADDR + 1);

    logic mask_wr, eoi_wr;
    logic [LINES-1:0] isr_d;

    assign mask_wr = wr_en && (wr_addr == MASK_ADDR);
    assign eoi_wr  = wr_en && (wr_addr == CMD_ADDR) && (wr_data[7:5] == EOI_TAG);
    assign pend    = req_in & ~mask_q;

    irqagg_pick #(.N(LINES)) u_pick (
        .pend    (pend),
        .in_svc  (isr_q),
        .win_vld (win_vld),
        .win_idx (win_idx)
    );

    always_comb begin
        isr_d = isr_q;
        if (eoi_wr) isr_d[wr_data[IDX_W-1:0]] = 1'b0;
        if (set_en) isr_d[set_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
            isr_q  <= '0;
        end else begin
            if (mask_wr) mask_q <= wr_data[LINES-1:0];
            isr_q <= isr_d;
        end
    end

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> mask_q == $past(wr_data[LINES-1:0])); // R2
    AST_BAD_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == CMD_ADDR && wr_data[7:5] != EOI_TAG && !set_en)
        |=> $stable(isr_q)); // R9
    AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> isr_q[$past(set_idx)]); // R6
    AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && !(set_en && set_idx == wr_data[IDX_W-1:0]))
        |=> !isr_q[$past(wr_data[IDX_W-1:0])]); // R8
    AST_WIN_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld |-> (req_in[win_idx] && !mask_q[win_idx] && !isr_q[win_idx])); // R7
endmodule

// File: rtl/irq_cascade_agg.sv
module irq_cascade_agg
    import irqagg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [23:0]       src_lvl,
    input  logic              wr_en,
    input  logic [11:0]       wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [11:0]       rd_addr,
    input  logic              rd_isr_sel,
    output logic [7:0]        rd_data,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic [11:0]       irq_vector
);
    localparam logic [VEC_W-1:0] VEC_TOP =
        VEC_BASE + (VEC_W'(SRC_N - 1) << VEC_SHIFT);

    logic [GROUPS-1:0][LINES-1:0] s_mask, s_isr, s_pend;
    logic [GROUPS-1:0]            s_win_vld;
    logic [GROUPS-1:0][IDX_W-1:0] s_win_idx;
    logic [GROUPS-1:0]            s_set_en;

    logic [LINES-1:0] casc_req, m_mask, m_isr, m_pend;
    logic             m_win_vld;
    logic [IDX_W-1:0] m_win_idx, m_set_idx;

    offer_st_t            state_q, state_d;
    logic [SRC_IDX_W-1:0] held_q, held_d, win_global;
    logic [1:0]           held_grp, pick_grp;
    logic [IDX_W-1:0]     held_line;
    logic                 commit;

    assign commit    = (state_q == ST_OFFER) && irq_ack;
    assign held_grp  = held_q[SRC_IDX_W-1:IDX_W];
    assign held_line = held_q[IDX_W-1:0];

    // Bank stages
    for (genvar g = 0; g < GROUPS; g++) begin : g_bank
        assign s_set_en[g] = commit && (held_grp == 2'(g));
        irqagg_stage #(.CMD_ADDR(bank_cmd_addr(g))) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .req_in  (src_lvl[g*LINES +: LINES]),
            .set_en  (s_set_en[g]),
            .set_idx (held_line),
            .mask_q  (s_mask[g]),
            .isr_q   (s_isr[g]),
            .pend    (s_pend[g]),
            .win_vld (s_win_vld[g]),
            .win_idx (s_win_idx[g])
        );
    end

    // Cascade wiring into the master, and master line back to bank
    always_comb begin
        casc_req  = '0;
        pick_grp  = '0;
        m_set_idx = '0;
        for (int g = 0; g < GROUPS; g++) begin
            casc_req[bank_master_line(g)] = s_win_vld[g];
            if (m_win_idx == IDX_W'(bank_master_line(g))) pick_grp = 2'(g);
            if (held_grp == 2'(g)) m_set_idx = IDX_W'(bank_master_line(g));
        end
    end

    irqagg_stage #(.CMD_ADDR(MASTER_CMD)) u_master (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .req_in  (casc_req),
        .set_en  (commit),
        .set_idx (m_set_idx),
        .mask_q  (m_mask),
        .isr_q   (m_isr),
        .pend    (m_pend),
        .win_vld (m_win_vld),
        .win_idx (m_win_idx)
    );

    assign win_global = {pick_grp, s_win_idx[pick_grp]};

    // Offer state machine: next-state logic
    always_comb begin
        state_d = state_q;
        held_d  = held_q;
        unique case (state_q)
            ST_IDLE: begin
                if (m_win_vld) begin          // present
                    state_d = ST_OFFER;
                    held_d  = win_global;
                end
            end
            ST_OFFER: begin
                if (irq_ack) begin            // take
                    state_d = ST_IDLE;
                end else if (!m_win_vld) begin // withdraw
                    state_d = ST_IDLE;
                end else begin                // retarget
                    held_d = win_global;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
        end
    end

    // Offer state machine: outputs
    always_comb begin
        irq_req    = (state_q == ST_OFFER);
        irq_vector = VEC_BASE + (VEC_W'(held_q) << VEC_SHIFT);
    end

    // Read port
    always_comb begin
        rd_data = '0;
        for (int g = 0; g < GROUPS; g++) begin
            if (rd_addr == bank_cmd_addr(g))
                rd_data = rd_isr_sel ? s_isr[g] : s_pend[g];
            if (rd_addr == ADDR_W'(bank_cmd_addr(g) + 1))
                rd_data = s_mask[g];
        end
        if (rd_addr == MASTER_CMD)
            rd_data = rd_isr_sel ? m_isr : m_pend;
        if (rd_addr == ADDR_W'(MASTER_CMD + 1))
            rd_data = m_mask;
    end

    AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vector[VEC_SHIFT-1:0] == '0 &&
                     irq_vector >= VEC_BASE && irq_vector <= VEC_TOP)); // R4
    AST_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack && !m_win_vld) |=> !irq_req); // R3
    AST_TAKE_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> !irq_req); // R6
    AST_MASTER_ISR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        m_isr[1] |-> !m_win_vld); // R7
endmodule

// File: tb/tb_irq_cascade_agg.sv
module tb_irq_cascade_agg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] src_lvl = '0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic        rd_isr_sel = 1'b0;
    logic [7:0]  rd_data;
    logic        irq_ack = 1'b0;
    logic        irq_req;
    logic [11:0] irq_vector;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // model state: index 0..2 banks, 3 master
    logic [7:0] m_mask [4];
    logic [7:0] m_isr  [4];

    irq_cascade_agg dut (.*);

    always #5 clk = ~clk;

    function automatic logic [11:0] cmd_of(input int s);
        case (s)
            0: return 12'h536;
            1: return 12'h53A;
            2: return 12'h53C;
            default: return 12'h534;
        endcase
    endfunction

    function automatic int mline(input int g);
        return (g == 0) ? 1 : (g == 1) ? 3 : 4;
    endfunction

    // lowest pending line not blocked by an in-service bit at or below it
    function automatic int pick8(input logic [7:0] p, input logic [7:0] s);
        for (int i = 0; i < 8; i++) begin
            if (s[i]) return -1;
            if (p[i]) return i;
        end
        return -1;
    endfunction

    function automatic int exp_win();
        int bw [3];
        logic [7:0] cr;
        int ml;
        cr = '0;
        for (int g = 0; g < 3; g++) begin
            bw[g] = pick8(src_lvl[g*8 +: 8] & ~m_mask[g], m_isr[g]);
            if (bw[g] >= 0) cr[mline(g)] = 1'b1;
        end
        ml = pick8(cr & ~m_mask[3], m_isr[3]);
        for (int g = 0; g < 3; g++)
            if (ml == mline(g)) return g * 8 + bw[g];
        return -1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        for (int s = 0; s < 4; s++) begin
            if (a == cmd_of(s) + 12'd1) m_mask[s] = d;
            if (a == cmd_of(s) && d[7:5] == 3'b111) m_isr[s][d[2:0]] = 1'b0;
        end
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic chk_out(input string req);
        int e;
        e = exp_win();
        check(irq_req == (e >= 0), req, irq_req, (e >= 0));
        if (e >= 0)
            check(irq_vector == 12'h800 + 12'(e << 4), req, irq_vector, 12'h800 + (e << 4));
    endtask

    task automatic rd_chk(input logic [11:0] a, input bit isel, input logic [7:0] expv,
                          input string req);
        rd_addr = a; rd_isr_sel = isel;
        #1;
        check(rd_data == expv, req, rd_data, expv);
    endtask

    task automatic take();
        int e;
        e = exp_win();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        if (e >= 0) begin
            m_isr[e / 8][e % 8] = 1'b1;
            m_isr[3][mline(e / 8)] = 1'b1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int s = 0; s < 4; s++) begin m_mask[s] = 8'hFF; m_isr[s] = 8'h00; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(irq_req == 1'b0, "R1", irq_req, 0);
        for (int s = 0; s < 4; s++) begin
            rd_chk(cmd_of(s) + 12'd1, 1'b0, 8'hFF, "R1");
            rd_chk(cmd_of(s), 1'b1, 8'h00, "R1");
        end

        // R2 everything masked: no request
        src_lvl = 24'h000200;
        settle();
        check(irq_req == 1'b0, "R2", irq_req, 0);

        // R2/R3/R4 enable cascade and banks
        wr(12'h535, 8'h44);
        wr(12'h537, 8'h00);
        wr(12'h53B, 8'h00);
        wr(12'h53D, 8'h00);
        rd_chk(12'h535, 1'b0, 8'h44, "R2");
        settle();
        chk_out("R3");
        check(irq_vector == 12'h890, "R4", irq_vector, 12'h890);
        rd_chk(12'h53A, 1'b0, 8'h02, "R10");
        rd_chk(12'h540, 1'b0, 8'h00, "R10");

        // R5 bank priority across master
        src_lvl = 24'h020204;
        settle();
        check(irq_vector == 12'h820, "R5", irq_vector, 12'h820);

        // R6 take, R7 blocking by master in-service
        take();
        rd_chk(12'h536, 1'b1, 8'h04, "R6");
        rd_chk(12'h534, 1'b1, 8'h02, "R6");
        settle();
        check(irq_req == 1'b0, "R7", irq_req, 0);

        // R9 malformed command and unmapped write
        wr(12'h536, 8'h62);
        wr(12'h538, 8'hE2);
        wr(12'h533, 8'h00);
        rd_chk(12'h536, 1'b1, 8'h04, "R9");
        rd_chk(12'h534, 1'b1, 8'h02, "R9");
        rd_chk(12'h537, 1'b0, 8'h00, "R9");

        // R8 bank EOI; master still in service
        wr(12'h536, 8'hE2);
        rd_chk(12'h536, 1'b1, 8'h00, "R8");
        rd_chk(12'h534, 1'b1, 8'h02, "R8");
        settle();
        check(irq_req == 1'b0, "R8", irq_req, 0);

        // R11 master EOI, line still high -> requests again
        wr(12'h534, 8'hE1);
        settle();
        check(irq_req == 1'b1, "R11", irq_req, 1);
        check(irq_vector == 12'h820, "R11", irq_vector, 12'h820);

        // R5 group order after bank 0 drops, R3 withdraw
        src_lvl = 24'h020200;
        settle();
        check(irq_vector == 12'h890, "R5", irq_vector, 12'h890);
        src_lvl = 24'h0;
        settle();
        check(irq_req == 1'b0, "R3", irq_req, 0);

        // R7 bank in-service blocks lower priority in its bank
        src_lvl = 24'h000030;
        settle();
        take();
        wr(12'h534, 8'hE1);
        settle();
        check(irq_req == 1'b0, "R7", irq_req, 0);
        wr(12'h536, 8'hE4);
        settle();
        chk_out("R11");

        // random phase
        for (int it = 0; it < 600; it++) begin
            src_lvl = 24'($urandom);
            if ($urandom_range(0, 3) == 0)
                wr(cmd_of($urandom_range(0, 2)) + 12'd1, 8'($urandom));
            if ($urandom_range(0, 9) == 0)
                wr(12'h535, 8'($urandom) & 8'hE5);
            settle();
            chk_out("R5");
            if (irq_req && $urandom_range(0, 1) == 1) begin
                take();
                settle();
                chk_out("R7");
            end
            if ($urandom_range(0, 2) == 0) begin
                int s;
                s = $urandom_range(0, 3);
                wr(cmd_of(s), {($urandom_range(0, 3) == 0) ? 3'b011 : 3'b111,
                               2'b00, 3'($urandom)});
            end
            begin
                int s;
                s = $urandom_range(0, 3);
                rd_chk(cmd_of(s), 1'b1, m_isr[s], "R8");
                rd_chk(cmd_of(s) + 12'd1, 1'b0, m_mask[s], "R2");
            end
            settle();
            chk_out("R11");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule